// File: doc/BRIEF.md
# Serial Sampling Converter Output Model

This block is a synthesizable stand-in for the digital side of a 12-bit sampling converter with a three-wire serial port. A system testbench or an FPGA loopback drives active-low chip-select and the serial clock into it, the way a host would drive the real part. The block answers on a data line that has its own output-enable, so the pad can be tri-stated. The conversion result comes from a parallel input word. The block latches that word when chip-select falls and then presents it to the host bit by bit. Analog behaviour and pin timing are not modelled.

Both host signals are oversampled in the block's own clock domain. A parameterised chain of synchronizer flops feeds the edge detection. Every decision is counted in falling serial-clock edges after chip-select falls. The first two edges form the sampling window. The second edge switches the driver on and sends a zero lead bit. The data then follows MSB first and is repeated LSB first without a second B0. After that the line is released. The block also reports its sequencing state, two power-down indications and a flag that is raised when chip-select falls while the serial clock is already high.

Top module: `scc_serial_port`

## Requirements
- R1: After reset, `sdo_oe_o` is 0, `state_o` is idle (0), `analog_pd_o` and `digital_pd_o` are 1, and `early_clk_o` is 0.
- R2: The word on `sample_i` is captured when chip-select falls. Changes on `sample_i` after that have no effect on the bits shifted out in that frame.
- R3: Counting falling serial-clock edges from chip-select low, the output stays disabled through edge 1. At edge 2, `sdo_oe_o` rises and `sdo_o` carries a 0 lead bit.
- R4: On edges 3 through 14, `sdo_o` carries bits 11 down to 0 of the captured word, in two's complement (800h most negative, 7FFh most positive). `state_o` is 2 (MSB-first) from edge 2 through edge 14.
- R5: On edges 15 through 25, `sdo_o` carries bits 1 up to 11, and `state_o` is 3 (LSB-first). At edge 26, `sdo_oe_o` falls and `state_o` becomes 4 (done).
- R6: A rise of chip-select at any point drops `sdo_oe_o` and returns `state_o` to idle. This also holds when a serial-clock fall arrives in the same cycle; that edge is not acted on.
- R7: `analog_pd_o` clears when chip-select falls. It sets at whichever comes first: chip-select rising, or falling edge 16. When `early_clk_o` is set, the edge is 14 instead of 16.
- R8: `digital_pd_o` is 1 exactly while chip-select is high, and the driver is never enabled while it is 1.
- R9: Once done, further serial-clock edges with chip-select low change nothing. Clock edges with chip-select high start no frame: the state stays idle and the output stays disabled.
- R10: `early_clk_o` is set when chip-select falls while the serial clock is high. It is cleared when chip-select falls while the serial clock is low.
- R11: `state_o` encodes idle=0, sampling=1, MSB-first=2, LSB-first=3, done=4. It is 1 between chip-select falling and edge 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the host pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip-select from the host, active low |
| sclk_i | input | 1 | Serial clock from the host |
| sample_i | input | DATA_W | Conversion word, two's complement, captured at chip-select fall |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Drive enable for the data pad; 0 means high impedance |
| state_o | output | 3 | Sequencing state code |
| analog_pd_o | output | 1 | Analog section powered down |
| digital_pd_o | output | 1 | Digital section powered down |
| early_clk_o | output | 1 | Chip-select fell while the serial clock was high |

## Verification
Two events can reach the sequencer in the same cycle: a chip-select rise and a serial-clock fall. In that cycle the release must win, and the pending edge must neither advance the frame nor drive a bit. The bench provokes the collision by changing both pins in the same time step. It does this at every edge position of a frame, so both pulses leave the synchronizers together. It then judges the result at the ports: the enable must be off, the state must be idle and analog power-down must be set. A stray bit or a done state would reveal that the edge was taken.

// File: rtl/scc_pkg.sv
package scc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SAMPLE = 3'd1,
      ST_MSB    = 3'd2,
      ST_LSB    = 3'd3,
      ST_DONE   = 3'd4
   } scc_state_e;
endpackage

// File: rtl/scc_pin_sync.sv
// Brings one host pin into the clk domain and flags each change of level.
module scc_pin_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o,
   output logic chg_o
);
   logic prev_q;

   generate
      if (STAGES == 0) begin : g_bypass
         assign level_o = pin_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL}};
            else        chain_q <= {chain_q[STAGES-2:0], pin_i};
         end
         assign level_o = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= level_o;
   end

   assign chg_o = prev_q ^ level_o;
endmodule

// File: rtl/scc_shift_seq.sv
// Edge counter, frame state and bit selection for the serial data line.
module scc_shift_seq
   import scc_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_fall_i,
   input  logic              cs_rise_i,
   input  logic              sclk_fall_i,
   input  logic              sclk_level_i,
   input  logic [DATA_W-1:0] sample_i,
   output logic              sdo_o,
   output logic              sdo_oe_o,
   output scc_state_e        state_o,
   output logic              early_o,
   output logic [$clog2(2*DATA_W+3)-1:0] cnt_o
);
   localparam int CNT_W = $clog2(2*DATA_W+3);
   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] C_NULL     = CNT_W'(2);
   localparam logic [CNT_W-1:0] C_MSB_LAST = CNT_W'(DATA_W+2);
   localparam logic [CNT_W-1:0] C_LSB_LAST = CNT_W'(2*DATA_W+1);

   logic [DATA_W-1:0] held_q;
   logic [CNT_W-1:0]  cnt_q, nxt_cnt, rel;
   logic [IDX_W-1:0]  bit_idx;
   scc_state_e        state_q, nxt_state;
   logic              oe_q, sdo_q, early_q, nxt_oe, nxt_sdo, live;

   assign live = (state_q != ST_IDLE) && (state_q != ST_DONE);

   always_comb begin
      nxt_cnt = cnt_q + CNT_W'(1);
      if (nxt_cnt <= C_MSB_LAST) rel = C_MSB_LAST - nxt_cnt;
      else                       rel = nxt_cnt - C_MSB_LAST;
      bit_idx = rel[IDX_W-1:0];
      if (nxt_cnt < C_NULL)           nxt_state = ST_SAMPLE;
      else if (nxt_cnt <= C_MSB_LAST) nxt_state = ST_MSB;
      else if (nxt_cnt <= C_LSB_LAST) nxt_state = ST_LSB;
      else                            nxt_state = ST_DONE;
      nxt_oe  = (nxt_cnt >= C_NULL) && (nxt_cnt <= C_LSB_LAST);
      nxt_sdo = (nxt_oe && (nxt_cnt > C_NULL)) ? held_q[bit_idx] : 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q  <= '0;
         cnt_q   <= '0;
         state_q <= ST_IDLE;
         oe_q    <= 1'b0;
         sdo_q   <= 1'b0;
         early_q <= 1'b0;
      end else if (cs_rise_i) begin
         cnt_q   <= '0;
         state_q <= ST_IDLE;
         oe_q    <= 1'b0;
         sdo_q   <= 1'b0;
      end else if (cs_fall_i) begin
         held_q  <= sample_i;
         cnt_q   <= '0;
         state_q <= ST_SAMPLE;
         oe_q    <= 1'b0;
         sdo_q   <= 1'b0;
         early_q <= sclk_level_i;
      end else if (sclk_fall_i && live) begin
         cnt_q   <= nxt_cnt;
         state_q <= nxt_state;
         oe_q    <= nxt_oe;
         sdo_q   <= nxt_sdo;
      end
   end

   assign sdo_o    = sdo_q;
   assign sdo_oe_o = oe_q;
   assign state_o  = state_q;
   assign early_o  = early_q;
   assign cnt_o    = cnt_q;

   assert_null_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_oe_o) |-> (!sdo_o && state_o == ST_MSB));
   assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_IDLE) |-> !sdo_oe_o);
   assert_release_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise_i |=> (state_o == ST_IDLE && !sdo_oe_o));
   assert_done_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_DONE && !cs_rise_i) |=> (state_o == ST_DONE));
   assert_start_sampling_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall_i |=> (state_o == ST_SAMPLE && !sdo_oe_o));
endmodule

// File: rtl/scc_power_track.sv
// Analog and digital power-down indications.
module scc_power_track #(
   parameter int DATA_W         = 12,
   parameter bit SHORT_ON_EARLY = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_fall_i,
   input  logic cs_rise_i,
   input  logic cs_high_i,
   input  logic early_i,
   input  logic [$clog2(2*DATA_W+3)-1:0] cnt_i,
   output logic analog_pd_o,
   output logic digital_pd_o
);
   localparam int CNT_W = $clog2(2*DATA_W+3);
   localparam logic [CNT_W-1:0] C_FULL  = CNT_W'(DATA_W+4);
   localparam logic [CNT_W-1:0] C_SHORT = CNT_W'(DATA_W+2);

   logic [CNT_W-1:0] limit;
   logic apd_q, dpd_q;

   generate
      if (SHORT_ON_EARLY) begin : g_short
         assign limit = early_i ? C_SHORT : C_FULL;
      end else begin : g_full
         assign limit = C_FULL;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         apd_q <= 1'b1;
         dpd_q <= 1'b1;
      end else begin
         dpd_q <= cs_high_i;
         if (cs_fall_i)                          apd_q <= 1'b0;
         else if (cs_rise_i || (cnt_i >= limit)) apd_q <= 1'b1;
      end
   end

   assign analog_pd_o  = apd_q;
   assign digital_pd_o = dpd_q;

   assert_wake_only_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(analog_pd_o) |-> $past(cs_fall_i));
   assert_sleep_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise_i |=> analog_pd_o);
endmodule

// File: rtl/scc_serial_port.sv
module scc_serial_port #(
   parameter int DATA_W         = 12,
   parameter int SYNC_STAGES    = 2,
   parameter bit SHORT_ON_EARLY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_i,
   input  logic              sclk_i,
   input  logic [DATA_W-1:0] sample_i,
   output logic              sdo_o,
   output logic              sdo_oe_o,
   output logic [2:0]        state_o,
   output logic              analog_pd_o,
   output logic              digital_pd_o,
   output logic              early_clk_o
);
   import scc_pkg::*;
   localparam int CNT_W = $clog2(2*DATA_W+3);

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("scc_serial_port: DATA_W must be at least 4");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("scc_serial_port: SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic cs_lvl, cs_chg, sclk_lvl, sclk_chg;
   logic cs_fall, cs_rise, sclk_fall, early;
   logic [CNT_W-1:0] cnt;
   scc_state_e state;

   scc_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_cs_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(cs_n_i), .level_o(cs_lvl), .chg_o(cs_chg));
   scc_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sclk_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(sclk_i), .level_o(sclk_lvl), .chg_o(sclk_chg));

   assign cs_fall   = cs_chg & ~cs_lvl;
   assign cs_rise   = cs_chg &  cs_lvl;
   assign sclk_fall = sclk_chg & ~sclk_lvl & ~cs_lvl;

   scc_shift_seq #(.DATA_W(DATA_W)) i_seq (
      .clk(clk), .rst_n(rst_n), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
      .sclk_fall_i(sclk_fall), .sclk_level_i(sclk_lvl), .sample_i(sample_i),
      .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .state_o(state), .early_o(early),
      .cnt_o(cnt));

   scc_power_track #(.DATA_W(DATA_W), .SHORT_ON_EARLY(SHORT_ON_EARLY)) i_pwr (
      .clk(clk), .rst_n(rst_n), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
      .cs_high_i(cs_lvl), .early_i(early), .cnt_i(cnt),
      .analog_pd_o(analog_pd_o), .digital_pd_o(digital_pd_o));

   assign state_o     = state;
   assign early_clk_o = early;

   assert_digital_implies_analog_R8: assert property (@(posedge clk) disable iff (!rst_n)
      digital_pd_o |-> (analog_pd_o && !sdo_oe_o));
   assert_state_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
      state_o <= 3'd4);
endmodule

// File: tb/test_scc_serial_port.sv
module test_scc_serial_port;
   localparam int DW = 12;

   logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0;
   logic [DW-1:0] word = '0;
   logic sdo, sdo_oe, apd, dpd, early;
   logic [2:0] state;
   int checks = 0, fails = 0;

   always #4 clk = ~clk;

   scc_serial_port #(.DATA_W(DW)) i_scc_serial_port (
      .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sample_i(word),
      .sdo_o(sdo), .sdo_oe_o(sdo_oe), .state_o(state), .analog_pd_o(apd),
      .digital_pd_o(dpd), .early_clk_o(early));

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (8) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_fall(); sclk = 1'b0; settle(); endtask
   task automatic do_rise(); sclk = 1'b1; settle(); endtask

   function automatic int exp_state(int n);
      if (n < 2)       return 1;
      if (n <= DW + 2) return 2;
      if (n <= 2*DW+1) return 3;
      return 4;
   endfunction

   function automatic int exp_bit(int n, logic [DW-1:0] w);
      if (n <= DW + 2) return int'(w[DW+2-n]);
      return int'(w[n-DW-2]);
   endfunction

   task automatic start(logic [DW-1:0] w, bit pre_high);
      sclk = pre_high;
      settle();
      word = w;
      cs_n = 1'b0;
      settle();
      word = ~w; // R2: later change must not reach the data
      chk("R10 early flag", int'(early), int'(pre_high));
      chk("R11 sampling state", int'(state), 1);
      chk("R3 disabled while sampling", int'(sdo_oe), 0);
      chk("R7 analog awake", int'(apd), 0);
      chk("R8 digital awake", int'(dpd), 0);
   endtask

   task automatic check_edge(int n, logic [DW-1:0] w, bit pre_high);
      int lim = pre_high ? DW + 2 : DW + 4;
      bit on = (n >= 2) && (n <= 2*DW+1);
      chk("R3/R5 enable", int'(sdo_oe), int'(on));
      chk("R11 state", int'(state), exp_state(n));
      chk("R7 analog pd", int'(apd), int'(n >= lim));
      if (n == 2)                       chk("R3 lead bit", int'(sdo), 0);
      else if (on && n <= DW + 2)       chk("R4 msb-first bit (R2)", int'(sdo), exp_bit(n, w));
      else if (on)                      chk("R5 lsb-first bit (R2)", int'(sdo), exp_bit(n, w));
   endtask

   task automatic full_frame(logic [DW-1:0] w, bit pre_high);
      start(w, pre_high);
      if (!pre_high) do_rise();
      for (int n = 1; n <= 2*DW+2; n++) begin
         do_fall();
         check_edge(n, w, pre_high);
         do_rise();
      end
      for (int x = 0; x < 3; x++) begin
         do_fall();
         chk("R9 done holds", int'(state), 4);
         chk("R9 stays released", int'(sdo_oe), 0);
         do_rise();
      end
      cs_n = 1'b1;
      sclk = 1'b0;
      settle();
      chk("R6 idle after rise", int'(state), 0);
      chk("R8 digital pd", int'(dpd), 1);
      chk("R7 analog pd", int'(apd), 1);
   endtask

   task automatic cut_frame(logic [DW-1:0] w, int k, bit together);
      start(w, 1'b0);
      do_rise();
      for (int n = 1; n < k; n++) begin
         do_fall();
         check_edge(n, w, 1'b0);
         do_rise();
      end
      if (together) begin
         sclk = 1'b0;
         cs_n = 1'b1;
         settle();
      end else begin
         do_fall();
         check_edge(k, w, 1'b0);
         cs_n = 1'b1;
         settle();
      end
      chk("R6 released", int'(sdo_oe), 0);
      chk("R6 idle", int'(state), 0);
      chk("R7 analog pd on rise", int'(apd), 1);
      chk("R8 digital pd", int'(dpd), 1);
      do_rise();
      do_fall();
      chk("R9 no frame without cs", int'(state), 0);
      chk("R9 no drive without cs", int'(sdo_oe), 0);
   endtask

   initial begin
      logic [DW-1:0] corners [6];
      corners = '{12'h800, 12'h7FF, 12'h000, 12'hFFF, 12'hA5A, 12'h5A5};
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      settle();
      chk("R1 enable", int'(sdo_oe), 0);
      chk("R1 state", int'(state), 0);
      chk("R1 analog pd", int'(apd), 1);
      chk("R1 digital pd", int'(dpd), 1);
      chk("R1 early flag", int'(early), 0);
      for (int i = 0; i < 6; i++) full_frame(corners[i], i[0]);
      for (int i = 0; i < 12; i++) full_frame(DW'((i * 337) ^ (i << 7)), i[1]);
      for (int k = 1; k <= 2*DW+3; k++) cut_frame(DW'(12'h3C9 + k), k, 1'b0);
      for (int k = 1; k <= 2*DW+3; k++) cut_frame(DW'(12'hC36 - k), k, 1'b1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule